// File: doc/BRIEF.md
# System Counter with Physical and Virtual Compare Timers

This block holds a 64-bit up-counter that serves as the shared time reference. It also holds one timer unit with two comparators. The counter advances by one on each cycle where the input tick enable is high, but only while software has enabled it and has not paused it. While the counter is stopped, software can preset its value half by half.

The physical comparator watches the raw count. The virtual comparator watches the raw count minus an offset that a hypervisor programs. Each comparator raises a level interrupt while its watched count is at or above its compare value. A compare value that is already behind the count therefore fires straight away.

Everything is reached through a small word-addressed register port with 32-bit data. The bus read path is combinational. A read of the low count word freezes the high word in a shadow register, so that a later read of the high word matches it.

Top module: `sys_timebase`

## Requirements
- R1: After reset the following hold. The count is zero. CTRL (address 0) reads 0. PCTL (address 9) and VCTL (address 12) read 6: bit 0 is enable = 0, bit 1 is mask = 1, and bit 2 is status = 1, because a zero count is at or above a zero compare value. Both interrupt outputs are low.
- R2: The count grows by exactly one at each clock edge where `tick_en` is high, CTRL bit 0 (enable) is 1 and CTRL bit 1 (pause) is 0. When the counter is disabled, it keeps its value.
- R3: While CTRL bit 1 (pause) is 1, ticks are ignored and the count keeps its value. Counting resumes from that value once pause is cleared.
- R4: START_LO (address 1) and START_HI (address 2) write the low and high 32-bit halves of the count, but only while enable is 0. While enable is 1 these writes are ignored.
- R5: A read of CNT_LO (address 3) returns count[31:0] and copies count[63:32] into a shadow register at the same edge. A read of CNT_HI (address 4) returns the shadow. The two halves stay consistent even if the counter carries into the high word in that same cycle.
- R6: The physical status, PCTL bit 2, is 1 exactly when the count is at or above the 64-bit compare value. The compare value is written through PCMP_LO (address 7) and PCMP_HI (address 8). The comparison is unsigned, and the status follows a compare write on the next cycle.
- R7: The virtual count is the count minus the offset, modulo 2^64. The offset is written through OFF_LO (address 5) and OFF_HI (address 6). The virtual status, VCTL bit 2, is 1 exactly when the virtual count is at or above the compare value written through VCMP_LO (address 10) and VCMP_HI (address 11).
- R8: Each interrupt output equals status AND enable AND NOT mask, where enable is control bit 0 and mask is control bit 1.
- R9: The offset can be written at any time, and the virtual status reflects a new offset on the very next cycle. The physical status does not depend on the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count tick strobe, one increment per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| phys_irq | output | 1 | Physical timer interrupt, level |
| virt_irq | output | 1 | Virtual timer interrupt, level |

## Verification
The hard case is a low-word read of the count and a carry into the high word landing in the same cycle. The bench presets the count to 0x0000_0000_FFFF_FFFF, then raises `tick_en` and reads CNT_LO in one cycle. It expects 0xFFFF_FFFF from the low read and 0 from the following CNT_HI read, even though the live count has become 0x1_0000_0000. It then reads the pair again and expects 0 and 1. The second collision is a compare write, or an offset write, that lands on the edge just before the status is read. In that case the bench checks that the status has already moved, and that only the comparator whose count was affected changed.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int ADDR_W = 4;
  localparam int NREG   = 13;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_START_LO = 4'd1,
    A_START_HI = 4'd2,
    A_CNT_LO  = 4'd3,
    A_CNT_HI  = 4'd4,
    A_OFF_LO  = 4'd5,
    A_OFF_HI  = 4'd6,
    A_PCMP_LO = 4'd7,
    A_PCMP_HI = 4'd8,
    A_PCTL    = 4'd9,
    A_VCMP_LO = 4'd10,
    A_VCMP_HI = 4'd11,
    A_VCTL    = 4'd12
  } reg_addr_e;

  // unsigned at-or-above test used by both comparators
  function automatic logic reached(cnt_t seen, cnt_t limit);
    return seen >= limit;
  endfunction

  // virtual view of the physical count, wraps modulo 2^CNT_W
  function automatic cnt_t virt_of(cnt_t phys, cnt_t off);
    return phys - off;
  endfunction

  // replace one 32-bit half of a 64-bit value
  function automatic cnt_t set_half(cnt_t v, logic hi, word_t w);
    cnt_t r;
    r = v;
    if (hi) r[CNT_W-1:DATA_W] = w;
    else    r[DATA_W-1:0]     = w;
    return r;
  endfunction
endpackage

// File: rtl/stb_counter.sv
module stb_counter
  import stb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_wdata,
  input  logic       start_wr_lo,
  input  logic       start_wr_hi,
  input  word_t      wdata,
  output cnt_t       count,
  output logic       cnt_en,
  output logic       cnt_pause,
  output logic       load_evt
);
  logic run;
  logic load_lo, load_hi;

  assign run      = cnt_en & ~cnt_pause & tick_en;
  assign load_lo  = start_wr_lo & ~cnt_en;
  assign load_hi  = start_wr_hi & ~cnt_en;
  assign load_evt = load_lo | load_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      cnt_en    <= 1'b0;
      cnt_pause <= 1'b0;
    end else begin
      if (ctrl_wr) {cnt_pause, cnt_en} <= ctrl_wdata;
      if (load_lo)      count <= set_half(count, 1'b0, wdata);
      else if (load_hi) count <= set_half(count, 1'b1, wdata);
      else if (run)     count <= count + 1'b1;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_en && !cnt_pause && !start_wr_lo && !start_wr_hi)
      |=> count == $past(count) + 1'b1);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!tick_en || cnt_pause || !cnt_en) && !load_evt) |=> $stable(count));

  // R4
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_wr_lo || start_wr_hi) && cnt_en && (cnt_pause || !tick_en))
      |=> $stable(count));
endmodule

// File: rtl/stb_cmp.sv
module stb_cmp
  import stb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cnt_t       seen,
  input  logic       cmp_wr_lo,
  input  logic       cmp_wr_hi,
  input  word_t      wdata,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  input  logic       base_jump,
  output logic [2:0] ctl_view,
  output logic       irq
);
  cnt_t cmp;
  logic status, tmr_en, tmr_mask;

  assign status   = reached(seen, cmp);
  assign irq      = status & tmr_en & ~tmr_mask;
  assign ctl_view = {status, tmr_mask, tmr_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp      <= '0;
      tmr_en   <= 1'b0;
      tmr_mask <= 1'b1;
    end else begin
      if (cmp_wr_lo) cmp <= set_half(cmp, 1'b0, wdata);
      if (cmp_wr_hi) cmp <= set_half(cmp, 1'b1, wdata);
      if (ctl_wr) {tmr_mask, tmr_en} <= ctl_wdata;
    end
  end

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !cmp_wr_lo && !cmp_wr_hi && !base_jump && seen != '1)
      |=> status);

  // R8
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_mask |-> !irq);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (tmr_en && status));
endmodule

// File: rtl/stb_regif.sv
module stb_regif
  import stb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  cnt_t              count,
  input  logic [1:0]        ctrl_view,
  input  cnt_t              off,
  input  logic [2:0]        pctl_view,
  input  logic [2:0]        vctl_view,
  input  cnt_t              pcmp_view,
  input  cnt_t              vcmp_view,
  output logic [NREG-1:0]   wr_sel,
  output word_t             rdata
);
  word_t shadow_hi;
  logic  lo_read;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = bus_wr && (bus_addr == ADDR_W'(i));
  end

  assign lo_read = bus_rd && (bus_addr == A_CNT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_hi <= '0;
    else if (lo_read) shadow_hi <= count[CNT_W-1:DATA_W];
  end

  always_comb begin
    rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:    rdata = word_t'(ctrl_view);
        A_CNT_LO:  rdata = count[DATA_W-1:0];
        A_CNT_HI:  rdata = shadow_hi;
        A_OFF_LO:  rdata = off[DATA_W-1:0];
        A_OFF_HI:  rdata = off[CNT_W-1:DATA_W];
        A_PCMP_LO: rdata = pcmp_view[DATA_W-1:0];
        A_PCMP_HI: rdata = pcmp_view[CNT_W-1:DATA_W];
        A_PCTL:    rdata = word_t'(pctl_view);
        A_VCMP_LO: rdata = vcmp_view[DATA_W-1:0];
        A_VCMP_HI: rdata = vcmp_view[CNT_W-1:DATA_W];
        A_VCTL:    rdata = word_t'(vctl_view);
        default:   rdata = '0;
      endcase
    end
  end

  // R5
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_read |=> shadow_hi == $past(count[CNT_W-1:DATA_W]));

  // R5
  shadow_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_read |=> $stable(shadow_hi));
endmodule

// File: rtl/sys_timebase.sv
module sys_timebase
  import stb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              phys_irq,
  output logic              virt_irq
);
  logic [NREG-1:0] wr_sel;
  cnt_t count, off, vcount;
  logic cnt_en, cnt_pause, load_evt, off_wr;
  logic [2:0] pctl_view, vctl_view;
  cnt_t pcmp_mirror, vcmp_mirror;
  logic unused_sel;

  assign unused_sel = ^{wr_sel[A_CNT_LO], wr_sel[A_CNT_HI]};
  assign off_wr     = wr_sel[A_OFF_LO] | wr_sel[A_OFF_HI];
  assign vcount     = virt_of(count, off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off         <= '0;
      pcmp_mirror <= '0;
      vcmp_mirror <= '0;
    end else begin
      if (wr_sel[A_OFF_LO])  off <= set_half(off, 1'b0, bus_wdata);
      if (wr_sel[A_OFF_HI])  off <= set_half(off, 1'b1, bus_wdata);
      if (wr_sel[A_PCMP_LO]) pcmp_mirror <= set_half(pcmp_mirror, 1'b0, bus_wdata);
      if (wr_sel[A_PCMP_HI]) pcmp_mirror <= set_half(pcmp_mirror, 1'b1, bus_wdata);
      if (wr_sel[A_VCMP_LO]) vcmp_mirror <= set_half(vcmp_mirror, 1'b0, bus_wdata);
      if (wr_sel[A_VCMP_HI]) vcmp_mirror <= set_half(vcmp_mirror, 1'b1, bus_wdata);
    end
  end

  stb_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .ctrl_wr    (wr_sel[A_CTRL]),
    .ctrl_wdata (bus_wdata[1:0]),
    .start_wr_lo(wr_sel[A_START_LO]),
    .start_wr_hi(wr_sel[A_START_HI]),
    .wdata      (bus_wdata),
    .count      (count),
    .cnt_en     (cnt_en),
    .cnt_pause  (cnt_pause),
    .load_evt   (load_evt)
  );

  stb_cmp u_phys (
    .clk      (clk),
    .rst_n    (rst_n),
    .seen     (count),
    .cmp_wr_lo(wr_sel[A_PCMP_LO]),
    .cmp_wr_hi(wr_sel[A_PCMP_HI]),
    .wdata    (bus_wdata),
    .ctl_wr   (wr_sel[A_PCTL]),
    .ctl_wdata(bus_wdata[1:0]),
    .base_jump(load_evt),
    .ctl_view (pctl_view),
    .irq      (phys_irq)
  );

  stb_cmp u_virt (
    .clk      (clk),
    .rst_n    (rst_n),
    .seen     (vcount),
    .cmp_wr_lo(wr_sel[A_VCMP_LO]),
    .cmp_wr_hi(wr_sel[A_VCMP_HI]),
    .wdata    (bus_wdata),
    .ctl_wr   (wr_sel[A_VCTL]),
    .ctl_wdata(bus_wdata[1:0]),
    .base_jump(load_evt | off_wr),
    .ctl_view (vctl_view),
    .irq      (virt_irq)
  );

  stb_regif u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .count    (count),
    .ctrl_view({cnt_pause, cnt_en}),
    .off      (off),
    .pctl_view(pctl_view),
    .vctl_view(vctl_view),
    .pcmp_view(pcmp_mirror),
    .vcmp_view(vcmp_mirror),
    .wr_sel   (wr_sel),
    .rdata    (bus_rdata)
  );

  // R9
  phys_offset_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_wr && !load_evt && !tick_en && !wr_sel[A_PCMP_LO] && !wr_sel[A_PCMP_HI])
      |=> $stable(pctl_view[2]));

  // R7
  virt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_wr && !load_evt && !tick_en) |=> $stable(vcount));
endmodule

// File: tb/sys_timebase_tb_top.sv
`timescale 1ns/1ps
module sys_timebase_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_en = 0;
  logic        bus_wr = 0;
  logic        bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        phys_irq, virt_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sys_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phys_irq(phys_irq), .virt_irq(virt_irq)
  );

  localparam logic [3:0] CTRL = 0, ST_LO = 1, ST_HI = 2, CN_LO = 3, CN_HI = 4,
    OF_LO = 5, OF_HI = 6, PC_LO = 7, PC_HI = 8, PCTL = 9,
    VC_LO = 10, VC_HI = 11, VCTL = 12;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(CN_LO, lo);
    rd(CN_HI, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(posedge clk);
    #1 tick_en = 0;
  endtask

  task automatic irq_at(input string req, input logic which, input logic exp);
    @(negedge clk);
    chk(req, which ? virt_irq : phys_irq, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v; logic [63:0] c;
    rd(CTRL, v);  chk("R1 ctrl", v, 0);
    rd64(c);      chk("R1 count", c, 0);
    rd(PCTL, v);  chk("R1 pctl", v, 6);
    rd(VCTL, v);  chk("R1 vctl", v, 6);
    irq_at("R1 phys_irq", 0, 0);
    irq_at("R1 virt_irq", 1, 0);
  endtask

  task automatic t_count();
    logic [63:0] c;
    wr(ST_LO, 100); wr(ST_HI, 0);
    rd64(c); chk("R4 start load", c, 100);
    wr(CTRL, 1); ticks(10);
    rd64(c); chk("R2 ten ticks", c, 110);
    wr(CTRL, 3); ticks(5);
    rd64(c); chk("R3 paused", c, 110);
    wr(CTRL, 1); ticks(3);
    rd64(c); chk("R3 resumed", c, 113);
    wr(CTRL, 0); ticks(2);
    rd64(c); chk("R2 disabled hold", c, 113);
  endtask

  task automatic t_start_ignored();
    logic [63:0] c;
    wr(CTRL, 1);
    wr(ST_LO, 7); wr(ST_HI, 9);
    rd64(c); chk("R4 start ignored while enabled", c, 113);
    wr(CTRL, 0);
  endtask

  task automatic t_phys();
    logic [31:0] v;
    wr(PC_HI, 0); wr(PC_LO, 50);
    rd(PCTL, v); chk("R6 past compare fires", v, 6);
    wr(PCTL, 1);
    irq_at("R8 enabled unmasked", 0, 1);
    wr(PC_LO, 120);
    rd(PCTL, v); chk("R6 future compare", v, 1);
    irq_at("R8 status low", 0, 0);
    wr(CTRL, 1); ticks(6);
    rd(PCTL, v); chk("R6 one below", v, 1);
    ticks(1);
    rd(PCTL, v); chk("R6 equal fires", v, 5);
    irq_at("R8 irq on reach", 0, 1);
    wr(CTRL, 0);
    wr(PC_HI, 32'h8000_0000);
    rd(PCTL, v); chk("R6 unsigned compare", v, 1);
    wr(PC_HI, 0);
  endtask

  task automatic t_mask();
    wr(PCTL, 3); irq_at("R8 masked", 0, 0);
    wr(PCTL, 0); irq_at("R8 disabled", 0, 0);
    wr(PCTL, 1); irq_at("R8 reenabled", 0, 1);
  endtask

  task automatic t_virtual();
    logic [31:0] v;
    wr(VC_HI, 0); wr(VC_LO, 500); wr(VCTL, 1);
    rd(VCTL, v); chk("R7 below compare", v, 1);
    wr(OF_LO, 300);
    rd(VCTL, v); chk("R9 offset wraps next cycle", v, 5);
    irq_at("R7 virt irq", 1, 1);
    rd(PCTL, v); chk("R9 phys unaffected", v, 5);
    wr(OF_LO, 0);
    rd(VCTL, v); chk("R9 offset cleared", v, 1);
    wr(OF_HI, 1);
    rd(VCTL, v); chk("R7 high offset wraps", v, 5);
    wr(OF_HI, 0); wr(OF_LO, 20); wr(VC_LO, 100);
    rd(VCTL, v); chk("R7 equal virtual", v, 5);
    wr(VC_LO, 101);
    rd(VCTL, v); chk("R7 one above virtual", v, 1);
    irq_at("R7 virt irq low", 1, 0);
    rd(OF_LO, v); chk("R7 offset readback", v, 20);
  endtask

  task automatic t_wrap_read();
    logic [31:0] lo, hi;
    wr(ST_LO, 32'hFFFF_FFFF); wr(ST_HI, 0); wr(CTRL, 1);
    @(negedge clk);
    tick_en = 1; bus_rd = 1; bus_addr = CN_LO;
    #1 lo = bus_rdata;
    @(posedge clk); #1;
    tick_en = 0; bus_rd = 0;
    rd(CN_HI, hi);
    chk("R5 low at carry", lo, 32'hFFFF_FFFF);
    chk("R5 shadow before carry", hi, 0);
    rd(CN_LO, lo); rd(CN_HI, hi);
    chk("R5 low after carry", lo, 0);
    chk("R5 high after carry", hi, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_count();
    t_start_ignored();
    t_phys();
    t_mask();
    t_virtual();
    t_wrap_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule